// File: doc/BRIEF.md
# Conversion Start Sequencer

This block is the control core of a successive-approximation converter. It watches an active-low start strobe and opens a conversion phase on each falling edge. During that phase it holds a busy flag high for a fixed count of clock cycles. It then returns to acquisition and marks the end of the phase with a one-cycle done pulse. A downstream latch can capture the result on that pulse. The analog sampling and the bit decisions are not part of this block; the conversion is modelled only by its length.

Three operating modes are offered. In the two fast modes every conversion needs a fresh falling edge on the strobe. In the impulse mode, a strobe still held low when the conversion ends makes the block time its own acquisition window and then start the next conversion unaided. Impulse mode also raises a low-power indication whenever the converter is not converting.

A power-down request never cuts a running conversion short. The request is remembered and takes effect once busy falls. Every pin here is plain control or status; there is no data stream, so no valid/ready handshake applies.

Top module: `adc_start_seq`

## Requirements
- R1: One clock edge after a cycle in which `start_n` is sampled low, having been sampled high in the previous cycle, `busy` rises and stays high for exactly `CONV_CYCLES` cycles (default 18).
- R2: Falling edges on `start_n` during a conversion neither lengthen it nor cause a further conversion after it ends.
- R3: A `pwrdn_req` pulse seen during a conversion does not shorten it. In the first cycle after `busy` falls, `sleep` is high, even if the request has already been withdrawn.
- R4: With `mode` = 2'b10 (impulse) and `start_n` low when `busy` falls, `busy` stays low for exactly `ACQ_CYCLES` cycles (default 6) and then rises again with no new edge. With `start_n` high at that moment, no further conversion starts.
- R5: With `mode` = 2'b01 (warp), 2'b00 or 2'b11 (normal), holding `start_n` low after a conversion starts nothing further.
- R6: After reset, a `start_n` that has been low since reset starts nothing. `start_n` must first be seen high and then low.
- R7: `low_pwr` is high only in impulse mode while neither converting nor asleep. In the other modes it is always low.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a conversion.
- R9: While and right after reset, `busy`, `done` and `sleep` are low.
- R10: While `pwrdn_req` is held in idle, `sleep` is high and strobe edges start nothing. Once the request drops, a new falling edge starts a conversion again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low conversion start strobe |
| pwrdn_req | input | 1 | Power-down request |
| mode | input | 2 | 00 normal, 01 warp, 10 impulse, 11 normal |
| busy | output | 1 | High during the conversion phase |
| done | output | 1 | One-cycle pulse when busy falls |
| low_pwr | output | 1 | Low-power indication in impulse mode |
| sleep | output | 1 | High while powered down |

## Verification
The end of a conversion can meet both a latched power-down request and an impulse-mode self-restart in the same cycle. The bench provokes this in impulse mode by holding `start_n` low and pulsing `pwrdn_req` in the middle of a conversion. The power-down must win. In the cycle after `busy` falls, `sleep` must be high and `busy` low. Afterwards `busy` must stay low, because a strobe that is only held low is not a fresh edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_ACQ   = 2'd2,
    ST_SLEEP = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    MD_NORMAL  = 2'b00,
    MD_WARP    = 2'b01,
    MD_IMPULSE = 2'b10,
    MD_NORM2   = 2'b11
  } seq_mode_t;
endpackage

// File: rtl/seq_strobe_edge.sv
module seq_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic fall
);
  logic prev_q;
  logic armed_q;

  // armed_q: strobe has been seen high since reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      prev_q <= start_n;
      if (start_n) armed_q <= 1'b1;
    end
  end

  assign fall = armed_q & prev_q & ~start_n;
endmodule

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == limit);
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import seq_pkg::*;
#(
  parameter int CONV_CYCLES = 18,
  parameter int ACQ_CYCLES  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_n,
  input  logic       pwrdn_req,
  input  logic [1:0] mode,
  output logic       busy,
  output logic       done,
  output logic       low_pwr,
  output logic       sleep
);
  localparam int MAXC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CONV_LIM = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] ACQ_LIM  = CW'(ACQ_CYCLES - 1);

  seq_state_t state_q, state_d;
  logic pd_pend_q, pd_pend_d;
  logic done_q, done_d;
  logic fall, hit, clr, impulse;
  logic [CW-1:0] limit;

  seq_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .fall(fall)
  );

  assign limit = (state_q == ST_CONV) ? CONV_LIM : ACQ_LIM;
  assign clr   = (state_d != state_q);

  seq_phase_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .limit(limit), .hit(hit)
  );

  assign impulse = (seq_mode_t'(mode) == MD_IMPULSE);

  always_comb begin
    state_d   = state_q;
    pd_pend_d = pd_pend_q;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pwrdn_req) state_d = ST_SLEEP;
        else if (fall) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (pwrdn_req) pd_pend_d = 1'b1;
        if (hit) begin
          done_d    = 1'b1;
          pd_pend_d = 1'b0;
          if (pd_pend_q || pwrdn_req)  state_d = ST_SLEEP;
          else if (impulse && !start_n) state_d = ST_ACQ;
          else                          state_d = ST_IDLE;
        end
      end
      ST_ACQ: begin
        if (pwrdn_req) state_d = ST_SLEEP;
        else if (hit) state_d = (impulse && !start_n) ? ST_CONV : ST_IDLE;
      end
      default: begin
        if (!pwrdn_req) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pd_pend_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pd_pend_q <= pd_pend_d;
      done_q    <= done_d;
    end
  end

  assign busy    = (state_q == ST_CONV);
  assign sleep   = (state_q == ST_SLEEP);
  assign done    = done_q;
  assign low_pwr = impulse && (state_q == ST_IDLE || state_q == ST_ACQ);

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && fall && !pwrdn_req) |=> busy);
  p_no_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit) |=> busy);
  p_pd_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwrdn_req) |=> (busy || sleep));
  p_auto_impulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(fall)) |-> ($past(mode) == MD_IMPULSE));
  p_lp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_pwr |-> (!busy && !sleep));
  p_done_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_adc_start_seq.sv
`timescale 1ns/1ps
module sim_adc_start_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic pwrdn_req = 1'b0;
  logic [1:0] mode = 2'b00;
  logic busy, done, low_pwr, sleep;
  int total = 0;
  int bad = 0;

  localparam int CONV = 18;
  localparam int ACQ  = 6;

  always #2.5 clk = ~clk;

  adc_start_seq #(.CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwrdn_req(pwrdn_req),
    .mode(mode), .busy(busy), .done(done), .low_pwr(low_pwr), .sleep(sleep)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge where busy=1; returns at the first negedge with busy=0
  task automatic meas(output int n);
    n = 1;
    forever begin
      tick();
      if (!busy || n > 200) break;
      n++;
    end
  endtask

  task automatic do_reset(input logic st);
    rst_n = 1'b0; start_n = st; pwrdn_req = 1'b0; mode = 2'b00;
    repeat (3) tick();
    chk(!busy && !done && !sleep, "R9 in reset", busy, 0);
    rst_n = 1'b1;
    tick();
    chk(!busy && !done && !sleep, "R9 after reset", {busy, done, sleep}, 0);
  endtask

  task automatic t_single(input logic [1:0] m);
    int n;
    mode = m; start_n = 1'b1; tick(); tick();
    start_n = 1'b0; tick();
    chk(busy, "R1 busy rise", busy, 1);
    meas(n);
    chk(n == CONV, "R1 length", n, CONV);
    chk(done, "R8 done at fall", done, 1);
    tick();
    chk(!done, "R8 done one cycle", done, 0);
    start_n = 1'b1; tick();
  endtask

  task automatic t_ignore();
    int n;
    mode = 2'b01; start_n = 1'b1; tick();
    start_n = 1'b0; tick();
    n = 1;
    forever begin
      if (n < 10) start_n = ~start_n; else start_n = 1'b0;
      tick();
      if (!busy || n > 200) break;
      n++;
    end
    chk(n == CONV, "R2 length kept", n, CONV);
    repeat (5) tick();
    chk(!busy, "R2 no extra conversion", busy, 0);
    start_n = 1'b1; tick();
  endtask

  task automatic t_pd_conv();
    int n;
    mode = 2'b00; start_n = 1'b1; tick();
    start_n = 1'b0; tick();
    repeat (4) tick();
    pwrdn_req = 1'b1; tick();
    pwrdn_req = 1'b0;
    meas(n);
    chk(n == CONV - 5, "R3 not shortened", n, CONV - 5);
    chk(sleep, "R3 deferred sleep", sleep, 1);
    tick();
    chk(!sleep, "R3 wake", sleep, 0);
    start_n = 1'b1; tick();
  endtask

  task automatic t_impulse();
    int n, g;
    bit lp_ok;
    mode = 2'b10; start_n = 1'b1; tick();
    chk(low_pwr, "R7 idle impulse", low_pwr, 1);
    start_n = 1'b0; tick();
    chk(!low_pwr, "R7 off while busy", low_pwr, 0);
    meas(n);
    chk(n == CONV, "R4 first length", n, CONV);
    g = 1; lp_ok = low_pwr;
    forever begin
      tick();
      if (busy || g > 200) break;
      g++;
      lp_ok &= low_pwr;
    end
    chk(g == ACQ, "R4 acquisition gap", g, ACQ);
    chk(lp_ok, "R7 low_pwr in acquisition", lp_ok, 1);
    start_n = 1'b1;
    meas(n);
    chk(n == CONV, "R4 second length", n, CONV);
    repeat (8) tick();
    chk(!busy, "R4 stop when strobe high", busy, 0);
  endtask

  task automatic t_warp_hold();
    int n;
    mode = 2'b01; start_n = 1'b1; tick();
    start_n = 1'b0; tick();
    meas(n);
    repeat (10) tick();
    chk(!busy, "R5 no restart warp", busy, 0);
    chk(!low_pwr, "R7 low_pwr off in warp", low_pwr, 0);
    start_n = 1'b1; tick();
  endtask

  task automatic t_powerup();
    int n;
    do_reset(1'b0);
    repeat (5) tick();
    chk(!busy, "R6 held low no start", busy, 0);
    start_n = 1'b1; tick();
    start_n = 1'b0; tick();
    chk(busy, "R6 start after high-low", busy, 1);
    meas(n);
    start_n = 1'b1; tick();
  endtask

  task automatic t_sleep();
    int n;
    mode = 2'b00; start_n = 1'b1; pwrdn_req = 1'b1; tick(); tick();
    chk(sleep, "R10 sleep", sleep, 1);
    start_n = 1'b0; tick(); tick();
    chk(!busy, "R10 edge ignored asleep", busy, 0);
    start_n = 1'b1; pwrdn_req = 1'b0; tick(); tick();
    chk(!sleep, "R10 awake", sleep, 0);
    start_n = 1'b0; tick();
    chk(busy, "R10 start after wake", busy, 1);
    meas(n);
    start_n = 1'b1; tick();
  endtask

  task automatic t_collide();
    int n;
    mode = 2'b10; start_n = 1'b1; tick();
    start_n = 1'b0; tick();
    repeat (3) tick();
    pwrdn_req = 1'b1; tick();
    pwrdn_req = 1'b0;
    meas(n);
    chk(sleep && !busy, "R3 sleep beats restart", sleep, 1);
    repeat (10) tick();
    chk(!busy, "R4 no restart after sleep", busy, 0);
    start_n = 1'b1; tick();
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_single(2'b00);
    t_single(2'b11);
    t_ignore();
    t_pd_conv();
    t_impulse();
    t_warp_hold();
    t_powerup();
    t_sleep();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule